// File: doc/BRIEF.md
# Read/Write Drain Arbiter for a DRAM Controller

This block sits beside the read and write queues of a DRAM memory controller and decides which of them the command path serves. Normally reads own the bus. When the write queue fills to a high watermark, the block switches to drain mode, holds reads off and releases queued writes one at a time. It goes back to reads once the write queue is empty, or once it has dropped to a low watermark while reads are waiting. The two watermarks give hysteresis: a nearly empty write queue is not drained to zero while reads are stalled, but writes keep flowing if nothing else needs the bus.

Each write is released just in time. After a command is issued, the datapath reports the cycle at which the data bus becomes free. The block moves the next decision earlier than that cycle by the worst-case precharge, activate and CAS delays, and never to a cycle that has already passed. Leaving drain mode adds a write-to-read turnaround to the bus-free time. The first read decision after a drain cannot come before that adjusted cycle. During read service, each read issue can move the pending decision earlier, but never later.

The block has its own free-running cycle counter, and every timestamp on its ports is counted in that timebase.

Top module: `rw_drain_arbiter`

## Requirements
- R1: The high and low watermarks are whole entry counts, each equal to floor(write depth × percent / 100) of its own percentage parameter.
- R2: In read mode, a write-queue count that is non-zero and at or above the high watermark puts the block in drain mode on the next cycle, with `mode_write` and `stop_reads` both 1 and `drain_writes` cleared to 0.
- R3: In drain mode, `pop_write` is a one-cycle pulse. It is raised only when `cycle_now` has reached `sched_cycle` and the write count is non-zero. Each pulse raises `drain_writes` by one. No further pulse comes until the `issued` strobe has reported that write.
- R4: When a write is reported through `issued` and drain mode continues, `sched_cycle` becomes the next-decision time of R5. The next `pop_write` is seen first when `cycle_now` equals that time plus one.
- R5: The next-decision time for a bus-free cycle B at cycle N is max(B − L, N) when B > L, and N otherwise, where L = tRP + tRCD + tCL.
- R6: After a reported write, drain mode ends if the write count is 0, or if it is at or below the low watermark while the read count is non-zero. Otherwise, drain mode continues even at or below the low watermark.
- R7: When drain mode ends, the next cycle shows `mode_write` = 0, `stop_reads` = 0, `drain_writes` = 0 and `sched_cycle` = B + tWTR, where B is the bus-free cycle of the last write.
- R8: In read mode, a read reported through `issued` sets `sched_cycle` to its R5 time if no decision is pending. If a decision is pending, it moves `sched_cycle` only when the new time is earlier. A decision stays pending until `cycle_now` reaches `sched_cycle`.
- R9: Reset leaves the block in read mode: `mode_write`, `stop_reads`, `pop_write`, `sched_cycle`, `drain_writes` and `cycle_now` are all 0. An empty write queue never starts a drain, so with both queues empty the block stays idle in read mode.
- R10: `cycle_now` counts up by exactly one every clock cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_count | input | $clog2(RD_DEPTH+1) | Read-queue occupancy |
| wr_count | input | $clog2(WR_DEPTH+1) | Write-queue occupancy |
| issued | input | 1 | A command (read in read mode, the popped write in drain mode) was issued this cycle |
| bus_busy_until | input | TS_W | Cycle at which the data bus frees after the issued command; sampled with `issued` |
| mode_write | output | 1 | 1 while draining writes, 0 while serving reads |
| stop_reads | output | 1 | Reads must not be issued |
| pop_write | output | 1 | One-cycle request to issue the head write |
| sched_cycle | output | TS_W | Earliest cycle of the next scheduling decision |
| drain_writes | output | DCNT_W | Writes released in the current drain |
| cycle_now | output | TS_W | Free-running cycle count that all timestamps refer to |

## Verification
The bench builds the block with a write depth of 10 and percentages of 75 and 35. Both products have a fractional part (7.5 and 3.5), so truncation to 7 and 3 shows at the ports: a count of 6 does not start a drain, and a count of 3 with no reads waiting keeps draining. The timing parameters sum to a lead of 9 cycles with a turnaround of 6. These small values put every branch of the next-time formula within reach: a bus-free cycle far ahead, one only slightly ahead, and one below the lead. Small values also keep the just-in-time pop timing and the pending-decision rules observable within a few dozen cycles.

// File: rtl/rwd_pkg.sv
package rwd_pkg;

  typedef enum logic [1:0] {
    ST_READ  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_ISSUE = 2'd2
  } drain_st_e;

  // Whole entries from a percentage of a queue depth (truncating).
  function automatic int unsigned pct_entries(input int unsigned depth,
                                              input int unsigned pct);
    return (depth * pct) / 100;
  endfunction

endpackage

// File: rtl/rwd_timebase.sv
module rwd_timebase #(
  parameter int unsigned TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] now_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) now_q <= '0;
    else        now_q <= now_q + TS_W'(1);
  end

endmodule

// File: rtl/rwd_drain_fsm.sv
module rwd_drain_fsm
  import rwd_pkg::*;
#(
  parameter int unsigned CW_RD  = 6,
  parameter int unsigned CW_WR  = 6,
  parameter int unsigned DCNT_W = 16,
  parameter int unsigned HI_TH  = 22,
  parameter int unsigned LO_TH  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW_RD-1:0]  rd_count,
  input  logic [CW_WR-1:0]  wr_count,
  input  logic              issued,
  input  logic              due,
  output logic              in_read,
  output logic              pop_write,
  output logic [DCNT_W-1:0] drain_writes,
  output logic              enter_ev,
  output logic              exit_ev,
  output logic              next_ev
);

  localparam logic [CW_WR-1:0] HI_V = CW_WR'(HI_TH);
  localparam logic [CW_WR-1:0] LO_V = CW_WR'(LO_TH);

  drain_st_e         st_q, st_d;
  logic              wr_any, rd_any, leave_ok, fire_ev, done_ev;
  logic              pop_q;
  logic [DCNT_W-1:0] wcnt_q;

  always_comb begin
    wr_any   = (wr_count != '0);
    rd_any   = (rd_count != '0);
    leave_ok = !wr_any || ((wr_count <= LO_V) && rd_any);
    enter_ev = (st_q == ST_READ) && wr_any && (wr_count >= HI_V);
    fire_ev  = (st_q == ST_WAIT) && due && wr_any;
    done_ev  = (st_q == ST_ISSUE) && issued;
    exit_ev  = (done_ev && leave_ok) || ((st_q == ST_WAIT) && !wr_any);
    next_ev  = done_ev && !leave_ok;

    st_d = st_q;
    if (enter_ev)      st_d = ST_WAIT;
    else if (exit_ev)  st_d = ST_READ;
    else if (fire_ev)  st_d = ST_ISSUE;
    else if (next_ev)  st_d = ST_WAIT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_READ;
      pop_q  <= 1'b0;
      wcnt_q <= '0;
    end else begin
      st_q  <= st_d;
      pop_q <= fire_ev;
      if (enter_ev || exit_ev) wcnt_q <= '0;
      else if (fire_ev)        wcnt_q <= wcnt_q + DCNT_W'(1);
    end
  end

  assign in_read      = (st_q == ST_READ);
  assign pop_write    = pop_q;
  assign drain_writes = wcnt_q;

endmodule

// File: rtl/rwd_sched.sv
module rwd_sched #(
  parameter int unsigned TS_W  = 32,
  parameter int unsigned LEAD  = 39,
  parameter int unsigned T_WTR = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] now,
  input  logic            issued,
  input  logic [TS_W-1:0] bus_busy_until,
  input  logic            in_read,
  input  logic            enter_ev,
  input  logic            exit_ev,
  input  logic            next_ev,
  output logic            due,
  output logic [TS_W-1:0] sched_q
);

  localparam logic [TS_W-1:0] LEAD_V = TS_W'(LEAD);
  localparam logic [TS_W-1:0] WTR_V  = TS_W'(T_WTR);

  // Earliest decision cycle: back off the worst-case row miss from the
  // bus-free cycle, never into the past.
  function automatic logic [TS_W-1:0] next_time(input logic [TS_W-1:0] busy,
                                                input logic [TS_W-1:0] t);
    logic [TS_W-1:0] early;
    if (busy > LEAD_V) begin
      early = busy - LEAD_V;
      return (early > t) ? early : t;
    end
    return t;
  endfunction

  logic            pend_q;
  logic [TS_W-1:0] busy_q, base, cand, turn;

  always_comb begin
    due  = (now >= sched_q);
    base = issued ? bus_busy_until : busy_q;
    turn = base + WTR_V;
    cand = next_time(bus_busy_until, now);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sched_q <= '0;
      pend_q  <= 1'b0;
      busy_q  <= '0;
    end else begin
      if (exit_ev)      busy_q <= turn;
      else if (issued)  busy_q <= bus_busy_until;

      if (exit_ev) begin
        sched_q <= turn;
        pend_q  <= 1'b1;
      end else if (enter_ev) begin
        sched_q <= now;
        pend_q  <= 1'b0;
      end else if (next_ev) begin
        sched_q <= cand;
      end else if (in_read && issued) begin
        if (!pend_q || (cand < sched_q)) sched_q <= cand;
        pend_q <= 1'b1;
      end else if (in_read && pend_q && due) begin
        pend_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rw_drain_arbiter.sv
module rw_drain_arbiter
  import rwd_pkg::*;
#(
  parameter int unsigned RD_DEPTH = 32,
  parameter int unsigned WR_DEPTH = 32,
  parameter int unsigned HI_PCT   = 70,
  parameter int unsigned LO_PCT   = 0,
  parameter int unsigned T_RP     = 14,
  parameter int unsigned T_RCD    = 14,
  parameter int unsigned T_CL     = 14,
  parameter int unsigned T_WTR    = 8,
  parameter int unsigned TS_W     = 32,
  parameter int unsigned DCNT_W   = 16,
  localparam int unsigned CW_RD   = $clog2(RD_DEPTH + 1),
  localparam int unsigned CW_WR   = $clog2(WR_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW_RD-1:0]  rd_count,
  input  logic [CW_WR-1:0]  wr_count,
  input  logic              issued,
  input  logic [TS_W-1:0]   bus_busy_until,
  output logic              mode_write,
  output logic              stop_reads,
  output logic              pop_write,
  output logic [TS_W-1:0]   sched_cycle,
  output logic [DCNT_W-1:0] drain_writes,
  output logic [TS_W-1:0]   cycle_now
);

  localparam int unsigned HI_TH = pct_entries(WR_DEPTH, HI_PCT);
  localparam int unsigned LO_TH = pct_entries(WR_DEPTH, LO_PCT);
  localparam int unsigned LEAD  = T_RP + T_RCD + T_CL;

  logic            due, in_read, enter_ev, exit_ev, next_ev;
  logic [TS_W-1:0] now;

  rwd_timebase #(.TS_W(TS_W)) u_time (
    .clk(clk), .rst_n(rst_n), .now_q(now)
  );

  rwd_drain_fsm #(
    .CW_RD(CW_RD), .CW_WR(CW_WR), .DCNT_W(DCNT_W),
    .HI_TH(HI_TH), .LO_TH(LO_TH)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .rd_count(rd_count), .wr_count(wr_count),
    .issued(issued), .due(due), .in_read(in_read), .pop_write(pop_write),
    .drain_writes(drain_writes), .enter_ev(enter_ev), .exit_ev(exit_ev),
    .next_ev(next_ev)
  );

  rwd_sched #(.TS_W(TS_W), .LEAD(LEAD), .T_WTR(T_WTR)) u_sched (
    .clk(clk), .rst_n(rst_n), .now(now), .issued(issued),
    .bus_busy_until(bus_busy_until), .in_read(in_read),
    .enter_ev(enter_ev), .exit_ev(exit_ev), .next_ev(next_ev),
    .due(due), .sched_q(sched_cycle)
  );

  assign mode_write = !in_read;
  assign stop_reads = !in_read;
  assign cycle_now  = now;

endmodule

// File: rtl/rwd_checker.sv
module rwd_checker #(
  parameter int unsigned TS_W   = 32,
  parameter int unsigned CW_RD  = 6,
  parameter int unsigned CW_WR  = 6,
  parameter int unsigned DCNT_W = 16,
  parameter int unsigned HI_TH  = 22,
  parameter int unsigned LO_TH  = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CW_RD-1:0]  rd_count,
  input logic [CW_WR-1:0]  wr_count,
  input logic              mode_write,
  input logic              stop_reads,
  input logic              pop_write,
  input logic [DCNT_W-1:0] drain_writes,
  input logic [TS_W-1:0]   cycle_now
);

  localparam logic [CW_WR-1:0] HI_V = CW_WR'(HI_TH);
  localparam logic [CW_WR-1:0] LO_V = CW_WR'(LO_TH);

  a_r3_pop_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pop_write |=> !pop_write);

  a_r3_pop_only_drain: assert property (@(posedge clk) disable iff (!rst_n)
    pop_write |-> mode_write);

  a_r3_pop_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pop_write) |-> ($past(wr_count) != '0));

  a_r3_pop_counts: assert property (@(posedge clk) disable iff (!rst_n)
    pop_write |-> (drain_writes == $past(drain_writes) + DCNT_W'(1)));

  a_r2_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_write && (wr_count != '0) && (wr_count >= HI_V))
      |=> (mode_write && stop_reads && (drain_writes == '0)));

  a_r9_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_write && (wr_count == '0)) |=> !mode_write);

  a_r6_hold_above_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_write && (wr_count > LO_V)) |=> mode_write);

  a_r7_exit_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_write) |-> ((drain_writes == '0) && !stop_reads));

  a_r10_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (cycle_now == $past(cycle_now) + TS_W'(1)));

endmodule

bind rw_drain_arbiter rwd_checker #(
  .TS_W(TS_W), .CW_RD(CW_RD), .CW_WR(CW_WR), .DCNT_W(DCNT_W),
  .HI_TH(HI_TH), .LO_TH(LO_TH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_count(rd_count), .wr_count(wr_count),
  .mode_write(mode_write), .stop_reads(stop_reads), .pop_write(pop_write),
  .drain_writes(drain_writes), .cycle_now(cycle_now)
);

// File: tb/tb_rw_drain_arbiter.sv
module tb_rw_drain_arbiter;

  localparam int unsigned RD_DEPTH = 8;
  localparam int unsigned WR_DEPTH = 10;
  localparam int unsigned TS_W     = 32;
  localparam int unsigned DCNT_W   = 16;
  localparam int unsigned CW_RD    = $clog2(RD_DEPTH + 1);
  localparam int unsigned CW_WR    = $clog2(WR_DEPTH + 1);
  localparam int unsigned LEAD     = 2 + 3 + 4;
  localparam int unsigned WTR      = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [CW_RD-1:0]  rd_count = '0;
  logic [CW_WR-1:0]  wr_count = '0;
  logic              issued = 1'b0;
  logic [TS_W-1:0]   bus_busy_until = '0;
  logic              mode_write, stop_reads, pop_write;
  logic [TS_W-1:0]   sched_cycle, cycle_now;
  logic [DCNT_W-1:0] drain_writes;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rw_drain_arbiter #(
    .RD_DEPTH(RD_DEPTH), .WR_DEPTH(WR_DEPTH), .HI_PCT(75), .LO_PCT(35),
    .T_RP(2), .T_RCD(3), .T_CL(4), .T_WTR(WTR), .TS_W(TS_W), .DCNT_W(DCNT_W)
  ) dut (
    .clk(clk), .rst_n(rst_n), .rd_count(rd_count), .wr_count(wr_count),
    .issued(issued), .bus_busy_until(bus_busy_until),
    .mode_write(mode_write), .stop_reads(stop_reads), .pop_write(pop_write),
    .sched_cycle(sched_cycle), .drain_writes(drain_writes),
    .cycle_now(cycle_now)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Bench restatement of the next-decision rule.
  function automatic logic [TS_W-1:0] exp_next(input logic [TS_W-1:0] b,
                                               input logic [TS_W-1:0] n);
    if (b <= TS_W'(LEAD)) return n;
    if (b - TS_W'(LEAD) < n) return n;
    return b - TS_W'(LEAD);
  endfunction

  // Strobe issued for one cycle; the edge sees cycle_now == c.
  task automatic issue(input bit absolute, input logic [TS_W-1:0] v,
                       output logic [TS_W-1:0] c, output logic [TS_W-1:0] b);
    c = cycle_now;
    b = absolute ? v : c + v;
    issued = 1'b1;
    bus_busy_until = b;
    @(negedge clk);
    issued = 1'b0;
  endtask

  task automatic wait_pop(output logic [TS_W-1:0] at);
    at = '0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pop_write) begin
        at = cycle_now;
        return;
      end
    end
    chk("R3 pop_write never seen", 0, 1);
  endtask

  task automatic t_reset;
    chk("R9 reset mode_write", mode_write, 0);
    chk("R9 reset stop_reads", stop_reads, 0);
    chk("R9 reset pop_write", pop_write, 0);
    chk("R9 reset sched_cycle", sched_cycle, 0);
    chk("R9 reset drain_writes", drain_writes, 0);
    chk("R9 reset cycle_now", cycle_now, 0);
    @(negedge clk);
    chk("R10 cycle_now after one cycle", cycle_now, 1);
    repeat (4) @(negedge clk);
    chk("R10 cycle_now after five cycles", cycle_now, 5);
  endtask

  task automatic t_idle_empty;
    rd_count = '0; wr_count = '0;
    repeat (5) @(negedge clk);
    chk("R9 idle empty mode_write", mode_write, 0);
    chk("R9 idle empty pop_write", pop_write, 0);
  endtask

  task automatic t_read_sched;
    logic [TS_W-1:0] c0, c1, c2, b, keep;
    issue(1'b0, 30, c0, b);
    chk("R5 far bus-free time", sched_cycle, exp_next(b, c0));
    keep = sched_cycle;
    issue(1'b0, 40, c1, b);
    chk("R8 later time ignored while pending", sched_cycle, keep);
    issue(1'b0, 25, c2, b);
    chk("R8 earlier time moves decision", sched_cycle, c2 + 16);
    while (cycle_now <= sched_cycle + 1) @(negedge clk);
    issue(1'b0, 2, c0, b);
    chk("R5 near bus-free clamps to now", sched_cycle, c0);
    @(negedge clk);
    issue(1'b1, 5, c1, b);
    chk("R5 bus-free below lead gives now", sched_cycle, c1);
  endtask

  task automatic t_drain_hysteresis;
    logic [TS_W-1:0] c, b, at;
    rd_count = '0; wr_count = 4'd6;
    repeat (3) @(negedge clk);
    chk("R1 six entries below truncated high mark", mode_write, 0);
    wr_count = 4'd7;
    @(negedge clk);
    chk("R2 drain entered", mode_write, 1);
    chk("R2 stop_reads raised", stop_reads, 1);
    chk("R2 drain counter cleared", drain_writes, 0);
    @(negedge clk);
    chk("R3 first pop", pop_write, 1);
    chk("R3 counter after first pop", drain_writes, 1);
    wr_count = 4'd6;
    repeat (2) begin
      @(negedge clk);
      chk("R3 no pop before issue report", pop_write, 0);
    end
    chk("R3 counter holds", drain_writes, 1);
    issue(1'b0, 20, c, b);
    chk("R4 next write time", sched_cycle, exp_next(b, c));
    wait_pop(at);
    chk("R4 pop timing", at, c + 20 - LEAD + 1);
    chk("R3 counter after second pop", drain_writes, 2);
    wr_count = 4'd5;
    issue(1'b0, 12, c, b);
    chk("R6 stays above low mark", mode_write, 1);
    wait_pop(at);
    wr_count = 4'd4;
    chk("R3 counter after third pop", drain_writes, 3);
    issue(1'b0, 12, c, b);
    wait_pop(at);
    wr_count = 4'd3;
    chk("R3 counter after fourth pop", drain_writes, 4);
    rd_count = '0;
    issue(1'b0, 12, c, b);
    chk("R6 at low mark without reads keeps draining", mode_write, 1);
    wait_pop(at);
    wr_count = 4'd2;
    rd_count = 4'd2;
    issue(1'b0, 15, c, b);
    chk("R6 exit at low mark with reads", mode_write, 0);
    chk("R7 stop_reads dropped", stop_reads, 0);
    chk("R7 drain counter cleared", drain_writes, 0);
    chk("R7 turnaround schedule", sched_cycle, b + WTR);
  endtask

  task automatic t_empty_exit;
    logic [TS_W-1:0] c, b, at;
    rd_count = '0; wr_count = 4'd7;
    @(negedge clk);
    chk("R2 second drain entered", mode_write, 1);
    wait_pop(at);
    wr_count = '0;
    issue(1'b0, 8, c, b);
    chk("R6 exit on empty write queue", mode_write, 0);
    chk("R7 turnaround after empty exit", sched_cycle, b + WTR);
    repeat (4) begin
      @(negedge clk);
      chk("R9 no drain on empty queue", mode_write, 0);
      chk("R9 no pop on empty queue", pop_write, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_idle_empty();
    t_read_sched();
    t_drain_hysteresis();
    t_empty_exit();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule